// File: doc/BRIEF.md
# Split-Half Access Bridge for Wide Control Registers

This block lets a master with a 32-bit data path reach a bank of 64-bit control registers. Each 64-bit register takes 64 bytes of address space. Within that space, the word at offset 0 holds the low half and the word at offset 4 holds the high half. One 32-bit holding latch bridges the two halves, and reads and writes share it.

A write updates a register only when the high half is written. The register then receives the new word on top and the latched word below, in a single strobe. A read of the low half returns the register's low word and parks its high word in the latch, and the read of the high half that follows returns that parked word. Because the latch is shared, a low-half read that falls between the two halves of a split write replaces the low half that write will commit.

On the bank side the bridge drives a 64-bit register interface: an index, a read strobe, a write strobe and write data. The bank answers with read data in the same cycle. Registers listed in a parameter mask are inert: they read as zero and ignore writes. Offsets that decode to no register are flagged as errors.

Top module: `split_acc_bridge`

## Requirements
- R1: With address bit 2 clear, a write loads only the holding latch with the write data. No write strobe reaches the bank.
- R2: With address bit 2 set, a write to a decoded, non-inert register gives one write strobe for the register index taken from address bits above bit 5. The write data is {request data, holding latch}, with the request data in bits 63:32.
- R3: With address bit 2 clear, a read strobes the bank. It returns bits 31:0 of the register and loads bits 63:32 into the holding latch.
- R4: With address bit 2 set, a read returns the holding latch and raises no bank read strobe.
- R5: The latch is shared. A low-half read between the low and high halves of a split write replaces the low word that the write commits.
- R6: An access is an error when address bits 5:3 or 1:0 are nonzero, or when the register number is NUM_REGS or above. Such an access sets the error flag in the response and returns all ones on a read. It strobes nothing and leaves the latch unchanged.
- R7: A register whose bit is set in INERT_MASK has no error. A low-half read returns zero and loads zero into the latch. Writes to it give no strobe.
- R8: After reset the holding latch is zero and no response is pending.
- R9: `req_ready` is high outside reset. Each accepted request produces exactly one response, in the next cycle. A write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Response present (one cycle after accept) |
| rsp_err | output | 1 | Access decoded to no register |
| rsp_rdata | output | 32 | Read word |
| reg_idx | output | IDX_W | Register index to bank |
| reg_rd_en | output | 1 | Bank read strobe |
| reg_wr_en | output | 1 | Bank write strobe |
| reg_wdata | output | 64 | Bank write data |
| reg_rdata | input | 64 | Bank read data, same cycle |

## Verification
The bench drives several stimulus patterns. Complete low-then-high write pairs separate a correct commit from an early or torn commit. A lone low-half write followed by a high-half read shows that the latch holds write data and that no strobe fires. A write pair split by a low-half read of a different register shows that the latch is shared. Misaligned, out-of-range and inert offsets separate error handling from inert handling. A long pseudo-random mix of halves, registers and idle cycles is compared each cycle against a behavioural model of the latch and bank.

// File: rtl/split_acc_pkg.sv
package split_acc_pkg;
  localparam int HALF_W     = 32;
  localparam int WIDE_W     = 2 * HALF_W;
  localparam int STRIDE_LSB = 6;   // 64-byte register spacing
  localparam int HALF_BIT   = 2;   // selects the upper word

  typedef struct packed {
    logic              valid;
    logic              err;
    logic [HALF_W-1:0] data;
  } rsp_t;
endpackage

// File: rtl/split_acc_rstsync.sv
module split_acc_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/split_acc_decode.sv
module split_acc_decode #(
  parameter int                  ADDR_W     = 12,
  parameter int                  NUM_REGS   = 16,
  parameter logic [NUM_REGS-1:0] INERT_MASK = '0,
  localparam int                 IDX_W      = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              inert,
  output logic              upper,
  output logic [IDX_W-1:0]  idx
);
  import split_acc_pkg::*;

  localparam int                RN_W   = ADDR_W - STRIDE_LSB;
  localparam logic [RN_W-1:0]   RN_LIM = RN_W'(NUM_REGS);

  logic [RN_W-1:0]     rnum;
  logic [NUM_REGS-1:0] inert_sel;
  logic                aligned;

  assign rnum    = addr[ADDR_W-1:STRIDE_LSB];
  assign idx     = rnum[IDX_W-1:0];
  assign upper   = addr[HALF_BIT];
  assign aligned = (addr[STRIDE_LSB-1:HALF_BIT+1] == '0) && (addr[HALF_BIT-1:0] == '0);
  assign hit     = aligned && (rnum < RN_LIM);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_inert
    assign inert_sel[g] = INERT_MASK[g] && (idx == IDX_W'(g));
  end

  assign inert = hit && (|inert_sel);
endmodule

// File: rtl/split_acc_latch.sv
module split_acc_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load_en) q_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= q_d;
  end
endmodule

// File: rtl/split_acc_resp.sv
module split_acc_resp
  import split_acc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  rsp_t rsp_d,
  output rsp_t rsp_q
);
  rsp_t rsp_n;

  always_comb begin
    rsp_n = rsp_d;
    if (!rsp_d.valid) rsp_n.data = rsp_q.data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= '0;
    else        rsp_q <= rsp_n;
  end
endmodule

// File: rtl/split_acc_bridge.sv
module split_acc_bridge #(
  parameter int                  ADDR_W     = 12,
  parameter int                  NUM_REGS   = 16,
  parameter logic [NUM_REGS-1:0] INERT_MASK = 16'h00C0,
  localparam int                 IDX_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              reg_rd_en,
  output logic              reg_wr_en,
  output logic [63:0]       reg_wdata,
  input  logic [63:0]       reg_rdata
);
  import split_acc_pkg::*;

  logic              rst_n_q;
  logic              fire, hit, inert, upper;
  logic              latch_ld;
  logic [HALF_W-1:0] latch_val, latch_q;
  rsp_t              rsp_d, rsp_q;

  split_acc_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_q));

  split_acc_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .INERT_MASK(INERT_MASK)) u_dec (
    .addr(req_addr), .hit(hit), .inert(inert), .upper(upper), .idx(reg_idx)
  );

  assign req_ready = rst_n_q;
  assign fire      = req_valid && req_ready;

  // bank strobes
  assign reg_rd_en = fire && !req_write && !upper && hit && !inert;
  assign reg_wr_en = fire &&  req_write &&  upper && hit && !inert;
  assign reg_wdata = {req_wdata, latch_q};

  // holding latch: loaded by any decoded low-half access
  always_comb begin
    latch_ld  = fire && hit && !upper;
    latch_val = req_wdata;
    if (!req_write) latch_val = inert ? '0 : reg_rdata[WIDE_W-1:HALF_W];
  end

  split_acc_latch #(.W(HALF_W)) u_latch (
    .clk(clk), .rst_n(rst_n_q), .load_en(latch_ld), .load_val(latch_val), .q(latch_q)
  );

  // response formation
  always_comb begin
    rsp_d.valid = fire;
    rsp_d.err   = fire && !hit;
    if (req_write)   rsp_d.data = '0;
    else if (!hit)   rsp_d.data = '1;
    else if (upper)  rsp_d.data = latch_q;
    else if (inert)  rsp_d.data = '0;
    else             rsp_d.data = reg_rdata[HALF_W-1:0];
  end

  split_acc_resp u_rsp (.clk(clk), .rst_n(rst_n_q), .rsp_d(rsp_d), .rsp_q(rsp_q));

  assign rsp_valid = rsp_q.valid;
  assign rsp_err   = rsp_q.err;
  assign rsp_rdata = rsp_q.data;
endmodule

// File: rtl/split_acc_bridge_chk.sv
module split_acc_bridge_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              reg_rd_en,
  input logic              reg_wr_en,
  input logic [63:0]       reg_wdata,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata
);
  logic fire;
  assign fire = req_valid && req_ready;

  a_r1_low_write_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && !req_addr[2]) |-> !reg_wr_en);

  a_r2_strobe_on_upper_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (fire && req_write && req_addr[2]));

  a_r2_upper_word_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_wdata[63:32] == req_wdata));

  a_r4_upper_read_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write && req_addr[2]) |-> !reg_rd_en);

  a_r9_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);

  a_r6_err_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write) |=> (rsp_err -> (rsp_rdata == 32'hFFFF_FFFF)));

  a_r9_write_rsp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write) |=> (rsp_rdata == 32'h0));
endmodule

bind split_acc_bridge split_acc_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_q), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/split_acc_bridge_bench.sv
module split_acc_bridge_bench;
  localparam int          AW    = 12;
  localparam int          NR    = 16;
  localparam logic [15:0] INERT = 16'h00C0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err, reg_rd_en, reg_wr_en;
  logic [31:0] rsp_rdata;
  logic [3:0]  reg_idx;
  logic [63:0] reg_wdata, reg_rdata;

  always #4 clk = ~clk;  // 125 MHz

  split_acc_bridge #(.ADDR_W(AW), .NUM_REGS(NR), .INERT_MASK(INERT)) u_split_acc_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .reg_idx(reg_idx), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // register bank environment
  logic [63:0] bank [NR];
  assign reg_rdata = bank[reg_idx];
  always @(posedge clk) if (reg_wr_en) bank[reg_idx] <= reg_wdata;

  // behavioural reference
  logic [63:0] mbank [NR];
  logic [31:0] mlatch;
  logic        e_valid, e_err;
  logic [31:0] e_data;
  string       e_tag;
  int          errors = 0, checks = 0;
  bit          done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(rsp_valid == e_valid, {e_tag, " rsp_valid (R9)"}, 64'(rsp_valid), 64'(e_valid));
    if (e_valid) begin
      chk(rsp_err == e_err, {e_tag, " rsp_err"}, 64'(rsp_err), 64'(e_err));
      chk(rsp_rdata == e_data, {e_tag, " rsp_rdata"}, 64'(rsp_rdata), 64'(e_data));
    end
    for (int i = 0; i < NR; i++)
      if (bank[i] != mbank[i]) chk(1'b0, {e_tag, " bank contents (R2)"}, bank[i], mbank[i]);
    checks++;
  endtask

  task automatic step(input bit v, input bit w, input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    int  rn;
    bit  ok, inr, hi, e_rd, e_wr;
    @(negedge clk);
    check_outputs();
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    rn  = int'(a >> 6);
    ok  = (a[5:3] == 3'd0) && (a[1:0] == 2'd0) && (rn < NR);
    inr = ok && INERT[rn[3:0]];
    hi  = a[2];
    e_rd = v && !w && !hi && ok && !inr;
    e_wr = v &&  w &&  hi && ok && !inr;
    #1;
    chk(reg_rd_en == e_rd, {tag, " reg_rd_en (R3/R4)"}, 64'(reg_rd_en), 64'(e_rd));
    chk(reg_wr_en == e_wr, {tag, " reg_wr_en (R1/R2)"}, 64'(reg_wr_en), 64'(e_wr));
    e_valid = v; e_err = v && !ok; e_tag = tag;
    if (v) begin
      if (w) e_data = 32'h0;
      else if (!ok) e_data = 32'hFFFF_FFFF;
      else if (hi) e_data = mlatch;
      else if (inr) e_data = 32'h0;
      else e_data = mbank[rn][31:0];
      if (e_wr) mbank[rn] = {d, mlatch};
      if (ok && !hi) mlatch = w ? d : (inr ? 32'h0 : mbank[rn][63:32]);
    end
  endtask

  function automatic logic [AW-1:0] ad(input int rn, input bit hi);
    return AW'(rn * 64 + (hi ? 4 : 0));
  endfunction

  initial begin
    for (int i = 0; i < NR; i++) begin
      bank[i]  = {32'hB000_0000 | 32'(i), 32'hA000_0000 | 32'(i)};
      mbank[i] = bank[i];
    end
    mlatch = 32'h0; e_valid = 1'b0; e_err = 1'b0; e_data = 32'h0; e_tag = "R8 reset";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after reset", 64'(req_ready), 64'd1);

    // R8: nothing pending, latch starts at zero
    step(0, 0, '0, '0, "R8 idle");
    step(1, 0, ad(0, 1), '0, "R8 latch zero");
    // R1: low write touches only the latch
    step(1, 1, ad(1, 0), 32'hAAAA_5555, "R1 low write");
    step(1, 0, ad(1, 1), '0, "R1 latch holds write word");
    // R2 / R3 / R4: full split write then split read
    step(1, 1, ad(2, 0), 32'h1111_1111, "R2 low");
    step(1, 1, ad(2, 1), 32'h2222_2222, "R2 commit");
    step(1, 0, ad(2, 0), '0, "R3 low read");
    step(1, 0, ad(2, 1), '0, "R4 high read");
    // R5: intervening low read corrupts a pending write
    step(1, 1, ad(3, 0), 32'h3333_3333, "R5 low");
    step(1, 0, ad(4, 0), '0, "R5 intervening read");
    step(1, 1, ad(3, 1), 32'h4444_4444, "R5 commit");
    step(1, 0, ad(3, 0), '0, "R5 readback");
    // R6: undecoded offsets
    step(1, 1, ad(5, 0), 32'h5555_0000, "R6 prime");
    step(1, 0, 12'h008, '0, "R6 offset bits5:3");
    step(1, 0, 12'h041, '0, "R6 offset bits1:0");
    step(1, 1, ad(16, 0), 32'hDEAD_BEEF, "R6 out of range write");
    step(1, 0, ad(17, 1), '0, "R6 out of range read");
    step(1, 1, ad(5, 1), 32'h6666_0000, "R6 latch kept");
    // R7: inert registers
    step(1, 1, ad(6, 0), 32'h7777_7777, "R7 low write");
    step(1, 1, ad(6, 1), 32'h8888_8888, "R7 high write");
    step(1, 0, ad(7, 0), '0, "R7 low read");
    step(1, 0, ad(7, 1), '0, "R7 high read");
    step(0, 1, ad(8, 1), 32'h9999_9999, "R9 no valid");
    step(0, 0, '0, '0, "R9 idle");

    // pseudo-random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      logic [AW-1:0] a;
      r = $urandom();
      a = ad(int'(r[4:0]) % 20, r[5]);
      if (r[9:6] == 4'd0) a = a | 12'h010;
      step(r[12:10] != 3'd0, r[13], a, $urandom(), "R2/R3 random mix");
    end
    step(0, 0, '0, '0, "R9 drain");
    step(0, 0, '0, '0, "R9 drain");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule